// File: doc/BRIEF.md
# MSI Capability Register File

This block keeps the message-signalled-interrupt capability state of a PCI-style endpoint function. Software reaches it through a dword-indexed configuration port with byte enables. It holds a control word, a message address of 32 or 64 bits, a 16-bit message data value, and, when built with per-vector masking, a mask word and a pending word. Every software write passes through a field-specific write mask. Read-only fields and unimplemented options stay fixed at their build-time values.

Beside the register state, the block drives its present settings to the message dispatcher: the enable, the log2 of the enabled vector count, the address, the data and the mask. The dispatcher reports vectors that wait behind a mask through set pulses, and clears them through clear pulses once it delivers them. The block also gates the function's legacy level interrupt, and enforces two rules on every write that touches the capability: it clamps an over-large vector count and it drops pending bits for vectors that are no longer enabled.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, the enable bit, the enabled-count field, both address words, the data word, the mask word and the pending word all read as zero.
- R2: The control word sits in bits 31:16 of dword index 0. Its layout is: bit 0 enable, bits 3:1 capable-count log2, bits 6:4 enabled-count log2, bit 7 64-bit-capable flag, bit 8 mask-capable flag, other bits zero. Only enable and the enabled-count field can be written, and the defaults read 0x0186 there. Bits 15:0 of dword 0 read zero.
- R3: Address low sits at index 1 and its bits 1:0 always read zero. With the 64-bit option, the address high word is at index 2 and is fully writable. Data is then at index 3, with all 16 bits writable in bits 15:0 and bits 31:16 reading zero. msi_addr and msi_data follow the registers.
- R4: Each byte-enable bit gates its own byte lane. Lanes whose enable is low keep their old value.
- R5: With per-vector masking, the mask is at the index after data. Only bits 0 to N-1 can be written, where N is the capable vector count, and the bits above read zero.
- R6: If a write leaves the function enabled and the enabled-count field above the capable count, the field takes the capable count. While the function is disabled, a larger value is stored unchanged.
- R7: intx_out equals intx_req while the function is disabled, and stays low while it is enabled.
- R8: After any write to an index inside the capability that leaves the function enabled, pending bits at or above 2^(enabled-count field) are cleared.
- R9: The pending word sits at the index after the mask and shows the bits set by pend_set. Software writes to it have no effect.
- R10: Asserting rst_n low mid-operation restores every register to its R1 state.
- R11: A read returns its value with cfg_rvalid exactly one cycle after cfg_rd. Indices beyond the capability read zero.
- R12: A pend_set bit sets the matching pending bit, and a pend_clr bit clears it, on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 3 | Dword index within the capability |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read completion, one cycle after cfg_rd |
| pend_set | input | NV | Dispatcher marks vectors pending |
| pend_clr | input | NV | Dispatcher clears delivered vectors |
| intx_req | input | 1 | Legacy interrupt request from the function |
| intx_out | output | 1 | Gated legacy interrupt |
| msi_en | output | 1 | Message interrupts enabled |
| msi_nvec_log2 | output | 3 | Enabled vector count, log2 |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | NV | Per-vector mask |
| msi_pend | output | NV | Per-vector pending bits |

## Verification
Register writes, the clamp, the pending trim and the pend_set and pend_clr pulses all take effect on the clock edge that samples them. The bench drives each stimulus at a falling edge and reads the outputs at the next falling edge. Read data arrives one edge after the strobe. The bench driver queues each expected read word as it issues the read, and the monitor pops the queue at the first falling edge where cfg_rvalid is high. intx_out is combinational and is checked half a cycle after intx_req or the enable changes.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int CW_EN      = 0;
  localparam int CW_CAP_LSB = 1;
  localparam int CW_CNT_LSB = 4;
  localparam int CW_A64     = 7;
  localparam int CW_PVM     = 8;

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/msi_ctrl_reg.sv
module msi_ctrl_reg #(
  parameter int unsigned CAP_LOG2 = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVMASK   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_touch,
  input  logic        be_hi,
  input  logic [7:0]  wbyte,
  output logic        en_q,
  output logic [2:0]  cnt_q,
  output logic        en_nxt,
  output logic [2:0]  cnt_nxt,
  output logic [15:0] cword
);
  import msi_cap_pkg::*;
  localparam logic [2:0] CAP3 = 3'(CAP_LOG2);

  always_comb begin
    en_nxt  = en_q;
    cnt_nxt = cnt_q;
    if (wr_ctrl && be_hi) begin
      en_nxt  = wbyte[CW_EN];
      cnt_nxt = wbyte[CW_CNT_LSB +: 3];
    end
    if (wr_touch && en_nxt && (cnt_nxt > CAP3)) begin
      cnt_nxt = CAP3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= 3'd0;
    end else if (wr_touch) begin
      en_q  <= en_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  always_comb begin
    cword                     = '0;
    cword[CW_EN]              = en_q;
    cword[CW_CAP_LSB +: 3]    = CAP3;
    cword[CW_CNT_LSB +: 3]    = cnt_q;
    cword[CW_A64]             = ADDR64;
    cword[CW_PVM]             = PVMASK;
  end
endmodule

// File: rtl/msi_msg_regs.sv
module msi_msg_regs #(
  parameter bit ADDR64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        wr_data,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [63:0] addr,
  output logic [15:0] data
);
  import msi_cap_pkg::*;

  logic [31:0] lo_q, lo_d;
  logic [15:0] data_q, data_d;

  always_comb begin
    lo_d   = be_merge(lo_q, wdata, be) & 32'hFFFF_FFFC;
    data_d = {be[1] ? wdata[15:8] : data_q[15:8],
              be[0] ? wdata[7:0]  : data_q[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (wr_lo) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (wr_data) data_q <= data_d;
  end

  generate
    if (ADDR64) begin : g_hi
      logic [31:0] hi_q, hi_d;
      always_comb hi_d = be_merge(hi_q, wdata, be);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_hi) hi_q <= hi_d;
      end
      assign addr = {hi_q, lo_q};
    end else begin : g_nohi
      logic unused_hi;
      assign unused_hi = wr_hi;
      assign addr = {32'h0, lo_q};
    end
  endgenerate

  assign data = data_q;
endmodule

// File: rtl/msi_vec_regs.sv
module msi_vec_regs #(
  parameter int unsigned NV     = 8,
  parameter bit          PVMASK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mask,
  input  logic [NV-1:0] wbits,
  input  logic [NV-1:0] wbit_en,
  input  logic          trim_en,
  input  logic [2:0]    cnt_nxt,
  input  logic [NV-1:0] pend_set,
  input  logic [NV-1:0] pend_clr,
  output logic [NV-1:0] mask,
  output logic [NV-1:0] pend
);
  generate
    if (PVMASK) begin : g_vec
      logic [NV-1:0] mask_q, mask_d, pend_q, pend_d, keep;
      logic          pend_upd;

      for (genvar i = 0; i < NV; i++) begin : g_bit
        assign mask_d[i] = wbit_en[i] ? wbits[i] : mask_q[i];
        assign keep[i]   = (32'(i) < (32'd1 << cnt_nxt));
      end

      always_comb begin
        pend_d = (pend_q | pend_set) & ~pend_clr;
        if (trim_en) pend_d = pend_d & keep;
        pend_upd = trim_en | (|pend_set) | (|pend_clr);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= mask_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q <= '0;
        else if (pend_upd) pend_q <= pend_d;
      end

      assign mask = mask_q;
      assign pend = pend_q;
    end else begin : g_novec
      logic unused_vec;
      assign unused_vec = ^{clk, rst_n, wr_mask, wbits, wbit_en, trim_en,
                            cnt_nxt, pend_set, pend_clr};
      assign mask = '0;
      assign pend = '0;
    end
  endgenerate
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
  parameter int unsigned CAP_LOG2 = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVMASK   = 1'b1,
  localparam int unsigned NV      = 1 << CAP_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [2:0]    cfg_idx,
  input  logic [3:0]    cfg_be,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          cfg_rvalid,
  input  logic [NV-1:0] pend_set,
  input  logic [NV-1:0] pend_clr,
  input  logic          intx_req,
  output logic          intx_out,
  output logic          msi_en,
  output logic [2:0]    msi_nvec_log2,
  output logic [63:0]   msi_addr,
  output logic [15:0]   msi_data,
  output logic [NV-1:0] msi_mask,
  output logic [NV-1:0] msi_pend
);
  localparam logic [2:0] IDX_DATA = ADDR64 ? 3'd3 : 3'd2;
  localparam logic [2:0] IDX_MASK = IDX_DATA + 3'd1;
  localparam logic [2:0] IDX_PEND = IDX_DATA + 3'd2;
  localparam logic [2:0] IDX_LAST = PVMASK ? IDX_PEND : IDX_DATA;

  logic          touch, en_nxt;
  logic [2:0]    cnt_nxt;
  logic [15:0]   cword;
  logic [NV-1:0] wbit_en;
  logic [31:0]   rd_d;

  assign touch = cfg_wr && (cfg_idx <= IDX_LAST);

  for (genvar i = 0; i < NV; i++) begin : g_ben
    assign wbit_en[i] = cfg_wr && (cfg_idx == IDX_MASK) && cfg_be[i/8];
  end

  msi_ctrl_reg #(.CAP_LOG2(CAP_LOG2), .ADDR64(ADDR64), .PVMASK(PVMASK)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(cfg_wr && (cfg_idx == 3'd0)), .wr_touch(touch),
    .be_hi(cfg_be[2]), .wbyte(cfg_wdata[23:16]),
    .en_q(msi_en), .cnt_q(msi_nvec_log2),
    .en_nxt(en_nxt), .cnt_nxt(cnt_nxt), .cword(cword)
  );

  msi_msg_regs #(.ADDR64(ADDR64)) u_msg (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(cfg_wr && (cfg_idx == 3'd1)),
    .wr_hi(ADDR64 && cfg_wr && (cfg_idx == 3'd2)),
    .wr_data(cfg_wr && (cfg_idx == IDX_DATA)),
    .wdata(cfg_wdata), .be(cfg_be),
    .addr(msi_addr), .data(msi_data)
  );

  msi_vec_regs #(.NV(NV), .PVMASK(PVMASK)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .wr_mask(cfg_wr && (cfg_idx == IDX_MASK)),
    .wbits(cfg_wdata[NV-1:0]), .wbit_en(wbit_en),
    .trim_en(touch && en_nxt), .cnt_nxt(cnt_nxt),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .mask(msi_mask), .pend(msi_pend)
  );

  always_comb begin
    rd_d = '0;
    if (cfg_idx == 3'd0)                        rd_d = {cword, 16'h0};
    else if (cfg_idx == 3'd1)                   rd_d = msi_addr[31:0];
    else if (ADDR64 && (cfg_idx == 3'd2))       rd_d = msi_addr[63:32];
    else if (cfg_idx == IDX_DATA)               rd_d = {16'h0, msi_data};
    else if (PVMASK && (cfg_idx == IDX_MASK))   rd_d = 32'(msi_mask);
    else if (PVMASK && (cfg_idx == IDX_PEND))   rd_d = 32'(msi_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_rvalid <= 1'b0;
    else        cfg_rvalid <= cfg_rd;
  end

  assign intx_out = intx_req & ~msi_en;
endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker #(
  parameter int unsigned CAP_LOG2 = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVMASK   = 1'b1,
  localparam int unsigned NV      = 1 << CAP_LOG2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cfg_rd,
  input logic [2:0]    cfg_idx,
  input logic          cfg_rvalid,
  input logic          intx_out,
  input logic          msi_en,
  input logic [2:0]    msi_nvec_log2,
  input logic [63:0]   msi_addr,
  input logic [NV-1:0] msi_pend
);
  localparam logic [2:0] LAST = (ADDR64 ? 3'd3 : 3'd2) + (PVMASK ? 3'd2 : 3'd0);

  logic [NV-1:0] above;
  always_comb begin
    for (int i = 0; i < NV; i++) above[i] = (i >= (1 << msi_nvec_log2));
  end

  assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_addr[1:0] == 2'b00);
  assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> (msi_nvec_log2 <= 3'(CAP_LOG2)));
  assert_intx_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> !intx_out);
  assert_trim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_idx <= LAST)) |=> (!msi_en || ((msi_pend & above) == '0)));
  assert_rd_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> !cfg_rvalid);
endmodule

bind msi_cap_regs msi_cap_checker #(.CAP_LOG2(CAP_LOG2), .ADDR64(ADDR64), .PVMASK(PVMASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
  .cfg_rvalid(cfg_rvalid), .intx_out(intx_out), .msi_en(msi_en),
  .msi_nvec_log2(msi_nvec_log2), .msi_addr(msi_addr), .msi_pend(msi_pend)
);

// File: tb/tb_msi_cap_regs.sv
module tb_msi_cap_regs;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_rd;
  logic [2:0] cfg_idx;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic cfg_rvalid;
  logic [NV-1:0] pend_set, pend_clr, msi_mask, msi_pend;
  logic intx_req, intx_out, msi_en;
  logic [2:0] msi_nvec_log2;
  logic [63:0] msi_addr;
  logic [15:0] msi_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  msi_cap_regs dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .pend_set(pend_set), .pend_clr(pend_clr), .intx_req(intx_req), .intx_out(intx_out),
    .msi_en(msi_en), .msi_nvec_log2(msi_nvec_log2), .msi_addr(msi_addr),
    .msi_data(msi_data), .msi_mask(msi_mask), .msi_pend(msi_pend)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic cfg_read(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = idx;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  // monitor: the read word is due at the first falling edge after the strobe
  always @(negedge clk) begin
    if (cfg_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected rvalid", 64'(1), 64'(0));
      end else begin
        check(tag_q.pop_front(), 64'(cfg_rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_idx = '0; cfg_be = '0;
    cfg_wdata = '0; pend_set = '0; pend_clr = '0; intx_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 reset state and read-only flags
    cfg_read(3'd0, 32'h0186_0000, "R1 R2 ctrl after reset");
    cfg_read(3'd1, 32'h0, "R1 addr lo after reset");
    check("R1 msi_en after reset", 64'(msi_en), 64'(0));

    // R3 address and data masks
    cfg_write(3'd1, 32'hFFFF_FFFF, 4'hF);
    cfg_read(3'd1, 32'hFFFF_FFFC, "R3 addr lo low bits");
    cfg_write(3'd2, 32'h1234_5678, 4'hF);
    cfg_read(3'd2, 32'h1234_5678, "R3 addr hi");
    check("R3 msi_addr", msi_addr, 64'h1234_5678_FFFF_FFFC);
    // R4 byte lanes
    cfg_write(3'd1, 32'h0000_00A5, 4'b0001);
    cfg_read(3'd1, 32'hFFFF_FFA4, "R4 single lane");
    cfg_write(3'd3, 32'hABCD_1234, 4'hF);
    cfg_read(3'd3, 32'h0000_1234, "R3 data");
    check("R3 msi_data", 64'(msi_data), 64'h1234);
    cfg_write(3'd3, 32'h0000_FF00, 4'b0010);
    check("R4 data upper lane", 64'(msi_data), 64'hFF34);

    // R5 mask width
    cfg_write(3'd4, 32'hFFFF_FFFF, 4'hF);
    cfg_read(3'd4, 32'h0000_00FF, "R5 mask writable bits");
    check("R5 msi_mask", 64'(msi_mask), 64'hFF);

    // R6 no clamp while disabled, clamp when enabled, R2 read-only fields
    cfg_write(3'd0, 32'h0070_0000, 4'b0100);
    cfg_read(3'd0, 32'h01F6_0000, "R6 no clamp when disabled");
    cfg_write(3'd0, 32'hFFFF_FFFF, 4'hF);
    cfg_read(3'd0, 32'h01B7_0000, "R6 R2 clamp on enable");
    check("R6 msi_nvec_log2", 64'(msi_nvec_log2), 64'd3);
    cfg_write(3'd0, 32'h0000_0000, 4'b0100);

    // R7 legacy interrupt gating
    @(negedge clk); intx_req = 1'b1;
    #1 check("R7 intx passes when disabled", 64'(intx_out), 64'(1));
    cfg_write(3'd0, 32'h0021_0000, 4'b0100);
    check("R7 intx blocked when enabled", 64'(intx_out), 64'(0));
    check("R6 count kept", 64'(msi_nvec_log2), 64'd2);

    // R12 / R9 / R8 pending handling
    @(negedge clk); pend_set = 8'hF3;
    @(negedge clk); pend_set = 8'h00;
    check("R12 pend set", 64'(msi_pend), 64'hF3);
    cfg_read(3'd5, 32'h0000_00F3, "R9 pending readable");
    cfg_write(3'd3, 32'h0000_5555, 4'hF);
    check("R8 trim above count", 64'(msi_pend), 64'h03);
    cfg_write(3'd5, 32'h0000_0000, 4'hF);
    cfg_read(3'd5, 32'h0000_0003, "R9 pending not writable");
    @(negedge clk); pend_clr = 8'h01;
    @(negedge clk); pend_clr = 8'h00;
    check("R12 pend clear", 64'(msi_pend), 64'h02);

    // R11 outside capability
    cfg_read(3'd6, 32'h0, "R11 index 6");
    cfg_read(3'd7, 32'h0, "R11 index 7");

    // R10 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_read(3'd0, 32'h0186_0000, "R10 ctrl");
    cfg_read(3'd1, 32'h0, "R10 addr lo");
    cfg_read(3'd2, 32'h0, "R10 addr hi");
    cfg_read(3'd3, 32'h0, "R10 data");
    cfg_read(3'd4, 32'h0, "R10 mask");
    cfg_read(3'd5, 32'h0, "R10 pending");
    check("R10 intx after reset", 64'(intx_out), 64'(1));

    repeat (2) @(negedge clk);
    check("R11 all reads completed", 64'(exp_q.size()), 64'(0));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule